// File: doc/BRIEF.md
# High-Precision Event Timer

This peripheral holds a 64-bit free-running up-counter and one comparator channel, reached over a simple synchronous 32-bit register port: address, write data, a write strobe and a combinational read-data return. Software programs the comparator with a 64-bit match value. When the running counter reaches that value, the channel raises its interrupt line.

The channel runs in one-shot or periodic mode. In periodic mode a stored period is added to the comparator at every match, so that the events repeat. The interrupt is signalled either as a held level, which software clears through a write-one-to-clear status bit, or as a one-cycle pulse. A 32-bit compare mode matches only the low halves of the counter and the comparator. A capabilities word reports the counter clock period in femtoseconds, so that software can work out the tick rate.

Top module: `evt_timer`

## Requirements
- R1: After reset the global configuration, status and counter words read 0. Both comparator halves read 0xFFFFFFFF. The channel configuration reads only the reset route value in bits 13:9. The interrupt output is 0.
- R2: The word at offset 0x04 reads the PERIOD_FS parameter. Offset 0x10 keeps bits 1:0 (bit 0 = run enable, bit 1 = legacy routing flag, stored only) and reads every other bit as 0. Any offset that is not listed here reads 0.
- R3: The counter (low half at 0xF0, high half at 0xF4) advances by one per clock while run enable is 1, with a carry from the low half into the high half, and holds while run enable is 0. A write to either half is taken only while run enable is 0.
- R4: The channel configuration at 0x100 stores and reads back bit 1 (level=1, edge=0), bit 2 (interrupt enable), bit 3 (periodic), bit 6 (value-set), bit 8 (32-bit compare) and bits 13:9 (route). All other bits read 0.
- R5: The comparator (low half at 0x108, high half at 0x10C) keeps values written while run enable is 0. In edge mode a match produces a pulse of exactly one cycle. A match occurs in a cycle where run enable and interrupt enable are both 1 and the counter equals the comparator, and the pulse is high in the following cycle.
- R6: In level mode a match sets status bit 0 at offset 0x20, and the interrupt output follows that bit. Writing 1 to the bit clears it, and writing 0 has no effect. In edge mode a match leaves the status bit at 0.
- R7: No match is detected while run enable is 0 or while interrupt enable is 0.
- R8: A comparator-half write made while periodic and value-set are both 1 also loads the same half of the period. Value-set stays 1 after a low-half write and clears after any high-half comparator write. In periodic mode each match adds the period to the comparator.
- R9: With 32-bit compare set, a match needs only the low 32 bits to be equal. Without it, all 64 bits must be equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Channel interrupt, either a held level or a one-cycle pulse |

## Verification
The bench builds the timer with a 12-bit address, a non-default period word of 41,666,667 fs and a reset route of 3. This makes the reset values of the capability word and the route field show at the ports as something other than zero. Periodic support is left on, so that the period register and the value-set sequence are present. The counter is preloaded near the 32-bit boundary to exercise the carry between halves. Comparator high halves that the counter never reaches separate the 32-bit compare mode from the full 64-bit compare.

// File: rtl/evt_pkg.sv
package evt_pkg;
   localparam int unsigned DATA_W  = 32;
   localparam int unsigned CNT_W   = 2 * DATA_W;
   localparam int unsigned ROUTE_W = 5;

   // register byte offsets
   localparam int unsigned OFS_CAP_HI = 32'h004;
   localparam int unsigned OFS_GCFG   = 32'h010;
   localparam int unsigned OFS_STS    = 32'h020;
   localparam int unsigned OFS_CNT_LO = 32'h0F0;
   localparam int unsigned OFS_CNT_HI = 32'h0F4;
   localparam int unsigned OFS_CFG    = 32'h100;
   localparam int unsigned OFS_CMP_LO = 32'h108;
   localparam int unsigned OFS_CMP_HI = 32'h10C;

   // channel configuration bit positions
   localparam int unsigned BIT_LEVEL    = 1;
   localparam int unsigned BIT_INTEN    = 2;
   localparam int unsigned BIT_PER      = 3;
   localparam int unsigned BIT_VSET     = 6;
   localparam int unsigned BIT_M32      = 8;
   localparam int unsigned BIT_ROUTE_LO = 9;

   typedef struct packed {
      logic [ROUTE_W-1:0] route;
      logic               mode32;
      logic               valset;
      logic               periodic;
      logic               int_en;
      logic               level;
   } chan_cfg_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter import evt_pkg::*; (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt
);
   localparam int unsigned HALF = CNT_W / 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (run) begin
         cnt <= cnt + CNT_W'(1);
      end else begin
         if (wr_lo) cnt[HALF-1:0]     <= wdata;
         if (wr_hi) cnt[CNT_W-1:HALF] <= wdata;
      end
   end
endmodule

// File: rtl/evt_channel.sv
module evt_channel import evt_pkg::*; #(
   parameter bit                 HAS_PERIODIC = 1'b1,
   parameter logic [ROUTE_W-1:0] RESET_ROUTE  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gen_en,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cfg_wr,
   input  logic              cmp_wr_lo,
   input  logic              cmp_wr_hi,
   input  logic              sts_clr,
   output chan_cfg_t         cfg,
   output logic [CNT_W-1:0]  cmp,
   output logic              sts,
   output logic              irq_out
);
   localparam int unsigned HALF = CNT_W / 2;

   logic [CNT_W-1:0] period;
   logic             eq, hit, load_per, pulse;

   assign eq       = cfg.mode32 ? (cnt[HALF-1:0] == cmp[HALF-1:0]) : (cnt == cmp);
   assign hit      = gen_en & cfg.int_en & eq;
   assign load_per = cfg.periodic & cfg.valset;

   generate
      if (HAS_PERIODIC) begin : g_period
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               period <= '0;
            end else begin
               if (cmp_wr_lo && load_per) period[HALF-1:0]     <= wdata;
               if (cmp_wr_hi && load_per) period[CNT_W-1:HALF] <= wdata;
            end
         end
      end else begin : g_no_period
         assign period = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg       <= '0;
         cfg.route <= RESET_ROUTE;
      end else begin
         if (cmp_wr_hi) cfg.valset <= 1'b0;
         if (cfg_wr) begin
            cfg.level    <= wdata[BIT_LEVEL];
            cfg.int_en   <= wdata[BIT_INTEN];
            cfg.periodic <= HAS_PERIODIC && wdata[BIT_PER];
            cfg.valset   <= wdata[BIT_VSET];
            cfg.mode32   <= wdata[BIT_M32];
            cfg.route    <= wdata[BIT_ROUTE_LO +: ROUTE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp <= '1;
      end else if (cmp_wr_lo || cmp_wr_hi) begin
         if (cmp_wr_lo) cmp[HALF-1:0]     <= wdata;
         if (cmp_wr_hi) cmp[CNT_W-1:HALF] <= wdata;
      end else if (hit && cfg.periodic) begin
         cmp <= cmp + period;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts   <= 1'b0;
         pulse <= 1'b0;
      end else begin
         if (hit && cfg.level) sts <= 1'b1;
         else if (sts_clr)     sts <= 1'b0;
         pulse <= hit & ~cfg.level;
      end
   end

   assign irq_out = cfg.level ? sts : pulse;
endmodule

// File: rtl/evt_rdmux.sv
module evt_rdmux import evt_pkg::*; #(
   parameter int unsigned ADDR_W    = 12,
   parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              gen_en,
   input  logic              legacy,
   input  logic              sts,
   input  logic [CNT_W-1:0]  cnt,
   input  chan_cfg_t         cfg,
   input  logic [CNT_W-1:0]  cmp,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned HALF = CNT_W / 2;
   localparam logic [ADDR_W-1:0] A_CAP_HI = ADDR_W'(OFS_CAP_HI);
   localparam logic [ADDR_W-1:0] A_GCFG   = ADDR_W'(OFS_GCFG);
   localparam logic [ADDR_W-1:0] A_STS    = ADDR_W'(OFS_STS);
   localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFS_CNT_LO);
   localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFS_CNT_HI);
   localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(OFS_CMP_LO);
   localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(OFS_CMP_HI);

   always_comb begin
      rdata = '0;
      case (bus_addr)
         A_CAP_HI: rdata = PERIOD_FS;
         A_GCFG:   rdata[1:0] = {legacy, gen_en};
         A_STS:    rdata[0] = sts;
         A_CNT_LO: rdata = cnt[HALF-1:0];
         A_CNT_HI: rdata = cnt[CNT_W-1:HALF];
         A_CFG: begin
            rdata[BIT_LEVEL] = cfg.level;
            rdata[BIT_INTEN] = cfg.int_en;
            rdata[BIT_PER]   = cfg.periodic;
            rdata[BIT_VSET]  = cfg.valset;
            rdata[BIT_M32]   = cfg.mode32;
            rdata[BIT_ROUTE_LO +: ROUTE_W] = cfg.route;
         end
         A_CMP_LO: rdata = cmp[HALF-1:0];
         A_CMP_HI: rdata = cmp[CNT_W-1:HALF];
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/evt_timer.sv
module evt_timer import evt_pkg::*; #(
   parameter int unsigned        ADDR_W       = 12,
   parameter logic [31:0]        PERIOD_FS    = 32'd10_000_000,
   parameter bit                 HAS_PERIODIC = 1'b1,
   parameter logic [ROUTE_W-1:0] RESET_ROUTE  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   output logic [31:0]       bus_rdata,
   output logic              irq_out
);
   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("evt_timer: ADDR_W must lie in 9..16");
      end
      if (PERIOD_FS == 32'd0) begin : g_bad_period
         $error("evt_timer: PERIOD_FS must be nonzero");
      end
   endgenerate

   logic gen_en, legacy, sts;
   logic cnt_wr_lo, cnt_wr_hi, cfg_wr, cmp_wr_lo, cmp_wr_hi, sts_clr, gcfg_wr;
   logic [CNT_W-1:0] cnt, cmp;
   chan_cfg_t cfg;

   assign gcfg_wr   = bus_we && (bus_addr == ADDR_W'(OFS_GCFG));
   assign sts_clr   = bus_we && (bus_addr == ADDR_W'(OFS_STS)) && bus_wdata[0];
   assign cnt_wr_lo = bus_we && (bus_addr == ADDR_W'(OFS_CNT_LO));
   assign cnt_wr_hi = bus_we && (bus_addr == ADDR_W'(OFS_CNT_HI));
   assign cfg_wr    = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
   assign cmp_wr_lo = bus_we && (bus_addr == ADDR_W'(OFS_CMP_LO));
   assign cmp_wr_hi = bus_we && (bus_addr == ADDR_W'(OFS_CMP_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_en <= 1'b0;
         legacy <= 1'b0;
      end else if (gcfg_wr) begin
         gen_en <= bus_wdata[0];
         legacy <= bus_wdata[1];
      end
   end

   evt_counter u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (gen_en),
      .wr_lo (cnt_wr_lo),
      .wr_hi (cnt_wr_hi),
      .wdata (bus_wdata),
      .cnt   (cnt)
   );

   evt_channel #(
      .HAS_PERIODIC (HAS_PERIODIC),
      .RESET_ROUTE  (RESET_ROUTE)
   ) u_channel (
      .clk       (clk),
      .rst_n     (rst_n),
      .gen_en    (gen_en),
      .cnt       (cnt),
      .wdata     (bus_wdata),
      .cfg_wr    (cfg_wr),
      .cmp_wr_lo (cmp_wr_lo),
      .cmp_wr_hi (cmp_wr_hi),
      .sts_clr   (sts_clr),
      .cfg       (cfg),
      .cmp       (cmp),
      .sts       (sts),
      .irq_out   (irq_out)
   );

   evt_rdmux #(
      .ADDR_W    (ADDR_W),
      .PERIOD_FS (PERIOD_FS)
   ) u_rdmux (
      .bus_addr (bus_addr),
      .gen_en   (gen_en),
      .legacy   (legacy),
      .sts      (sts),
      .cnt      (cnt),
      .cfg      (cfg),
      .cmp      (cmp),
      .rdata    (bus_rdata)
   );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk import evt_pkg::*; (
   input logic             clk,
   input logic             rst_n,
   input logic             gen_en,
   input logic [CNT_W-1:0] cnt,
   input logic             cnt_wr,
   input logic             cfg_level,
   input logic             cfg_int_en,
   input logic             cfg_periodic,
   input logic             cfg_valset,
   input logic             sts,
   input logic             irq_out,
   input logic             sts_clr,
   input logic             cfg_wr,
   input logic             cmp_wr,
   input logic             cmp_wr_hi
);
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      gen_en |=> cnt == $past(cnt) + CNT_W'(1)); // R3

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_en && !cnt_wr) |=> $stable(cnt)); // R3

   AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_level && !cfg_periodic && irq_out && !cfg_wr && !cmp_wr) |=> !irq_out); // R5

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_level && irq_out && !sts_clr && !cfg_wr) |=> irq_out); // R6

   AST_STS_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts) |-> $past(cfg_level)); // R6

   AST_NO_MATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((!gen_en || !cfg_int_en) && !cfg_wr) |=> !$rose(irq_out)); // R7

   AST_VALSET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_wr_hi && !cfg_wr) |=> !cfg_valset); // R8
endmodule

bind evt_timer evt_timer_chk u_evt_timer_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .gen_en       (gen_en),
   .cnt          (cnt),
   .cnt_wr       (cnt_wr_lo | cnt_wr_hi),
   .cfg_level    (cfg.level),
   .cfg_int_en   (cfg.int_en),
   .cfg_periodic (cfg.periodic),
   .cfg_valset   (cfg.valset),
   .sts          (sts),
   .irq_out      (irq_out),
   .sts_clr      (sts_clr),
   .cfg_wr       (cfg_wr),
   .cmp_wr       (cmp_wr_lo | cmp_wr_hi),
   .cmp_wr_hi    (cmp_wr_hi)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
   import evt_pkg::*;

   localparam int          CLK_PERIOD = 10;
   localparam int unsigned AW         = 12;
   localparam logic [31:0] PER_FS     = 32'd41_666_667;
   localparam logic [4:0]  RST_ROUTE  = 5'd3;
   localparam logic [31:0] CFG_MASK   = 32'h0000_3F4E;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [31:0]    wdata = '0;
   logic           we = 1'b0;
   logic [31:0]    rdata;
   logic           irq;
   int             tests = 0;
   int             fails = 0;
   bit             done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_timer #(
      .ADDR_W       (AW),
      .PERIOD_FS    (PER_FS),
      .HAS_PERIODIC (1'b1),
      .RESET_ROUTE  (RST_ROUTE)
   ) u_evt_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_we    (we),
      .bus_rdata (rdata),
      .irq_out   (irq)
   );

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // every task starts just after a falling edge and ends on one
   task automatic wr(int unsigned a, logic [31:0] d);
      addr = AW'(a); wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(int unsigned a, output logic [31:0] d);
      addr = AW'(a); we = 1'b0;
      #1 d = rdata;
      @(negedge clk);
   endtask

   task automatic observe(int w, output logic [63:0] m);
      m = '0;
      for (int j = 1; j <= w; j++) begin
         @(negedge clk);
         m[j-1] = irq;
      end
   endtask

   // expected interrupt pattern: bit j-1 is the output j cycles after enabling
   function automatic logic [63:0] exp_mask(int d, int t, int w, bit lvl, bit per, bit ok);
      logic [63:0] m = '0;
      if (ok) begin
         for (int j = 1; j <= w; j++) begin
            if (lvl)      m[j-1] = (j >= d + 1);
            else if (per) m[j-1] = (j >= d + 1) && (((j - d - 1) % t) == 0);
            else          m[j-1] = (j == d + 1);
         end
      end
      return m;
   endfunction

   task automatic run(string tag, logic [31:0] v, int d, int t, logic [31:0] chi,
                      logic [31:0] cfgw, int w, bit lvl, bit per, bit ok);
      logic [31:0] r;
      logic [63:0] m;
      wr(OFS_GCFG, 32'h0);
      wr(OFS_STS, 32'h1);
      wr(OFS_CFG, per ? (cfgw | 32'h40) : cfgw);
      wr(OFS_CNT_LO, v);
      wr(OFS_CNT_HI, 32'h0);
      if (per) begin
         wr(OFS_CMP_LO, 32'(t));
         rd(OFS_CFG, r);
         check("R8", "value-set kept after low-half write", 64'(r[6]), 64'd1);
         wr(OFS_CMP_HI, 32'h0);
         rd(OFS_CFG, r);
         check("R8", "value-set cleared by high-half write", 64'(r[6]), 64'd0);
      end
      wr(OFS_CMP_LO, v + 32'(d));
      wr(OFS_CMP_HI, chi);
      rd(OFS_CMP_LO, r);
      check("R5", "comparator low kept while stopped", 64'(r), 64'(v + 32'(d)));
      rd(OFS_CMP_HI, r);
      check("R5", "comparator high kept while stopped", 64'(r), 64'(chi));
      wr(OFS_GCFG, 32'h1);
      observe(w, m);
      check(tag, "interrupt pattern", m, exp_mask(d, t, w, lvl, per, ok));
   endtask

   initial begin
      logic [31:0] r, r2, v;
      int          d, seed_sink;
      seed_sink = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", "irq after reset", 64'(irq), 64'd0);
      rd(OFS_GCFG, r);   check("R1", "gcfg reset", 64'(r), 64'd0);
      rd(OFS_STS, r);    check("R1", "status reset", 64'(r), 64'd0);
      rd(OFS_CNT_LO, r); check("R1", "counter low reset", 64'(r), 64'd0);
      rd(OFS_CNT_HI, r); check("R1", "counter high reset", 64'(r), 64'd0);
      rd(OFS_CMP_LO, r); check("R1", "comparator low reset", 64'(r), 64'hFFFF_FFFF);
      rd(OFS_CMP_HI, r); check("R1", "comparator high reset", 64'(r), 64'hFFFF_FFFF);
      rd(OFS_CFG, r);    check("R1", "channel cfg reset", 64'(r), 64'({RST_ROUTE, 9'd0}));

      // R2 capability word, global config, unimplemented offsets
      rd(OFS_CAP_HI, r); check("R2", "period word", 64'(r), 64'(PER_FS));
      rd(32'h000, r);    check("R2", "offset 0x00 reads zero", 64'(r), 64'd0);
      rd(32'h030, r);    check("R2", "offset 0x30 reads zero", 64'(r), 64'd0);
      rd(32'h104, r);    check("R2", "offset 0x104 reads zero", 64'(r), 64'd0);
      wr(OFS_GCFG, 32'hFFFF_FFFF);
      rd(OFS_GCFG, r);   check("R2", "gcfg keeps two bits", 64'(r), 64'd3);
      wr(OFS_GCFG, 32'h2);
      rd(OFS_GCFG, r);   check("R2", "legacy flag alone", 64'(r), 64'd2);
      wr(OFS_GCFG, 32'h0);

      // R3 counter: hold, load, step, ignored writes, carry
      wr(OFS_CNT_LO, 32'h100);
      wr(OFS_CNT_HI, 32'h2);
      rd(OFS_CNT_LO, r);
      repeat (5) @(negedge clk);
      rd(OFS_CNT_LO, r2);
      check("R3", "counter holds while stopped", 64'(r2), 64'(r));
      check("R3", "counter low loaded", 64'(r), 64'h100);
      rd(OFS_CNT_HI, r); check("R3", "counter high loaded", 64'(r), 64'h2);
      wr(OFS_GCFG, 32'h1);
      repeat (7) @(negedge clk);
      wr(OFS_GCFG, 32'h0);
      rd(OFS_CNT_LO, r); check("R3", "counter advances one per cycle", 64'(r), 64'h108);
      wr(OFS_GCFG, 32'h1);
      wr(OFS_CNT_LO, 32'h0);
      wr(OFS_GCFG, 32'h0);
      rd(OFS_CNT_LO, r); check("R3", "write ignored while running", 64'(r), 64'h10A);
      wr(OFS_CNT_LO, 32'hFFFF_FFFF);
      wr(OFS_CNT_HI, 32'h5);
      wr(OFS_GCFG, 32'h1);
      wr(OFS_GCFG, 32'h0);
      rd(OFS_CNT_LO, r); check("R3", "low half wraps", 64'(r), 64'h0);
      rd(OFS_CNT_HI, r); check("R3", "carry into high half", 64'(r), 64'h6);

      // R4 channel configuration fields, random words
      for (int i = 0; i < 6; i++) begin
         v = $urandom;
         wr(OFS_CFG, v);
         rd(OFS_CFG, r);
         check("R4", "channel cfg readback", 64'(r), 64'(v & CFG_MASK));
      end
      wr(OFS_CFG, 32'h0);

      // R5 edge one-shot, directed distance zero then random distances
      run("R5", 32'h0000_1000, 0, 1, 32'h0, 32'h4, 6, 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 8; i++) begin
         v = $urandom & 32'h7FFF_FFFF;
         d = int'($urandom % 41);
         run("R5", v, d, 1, 32'h0, 32'h4, d + 8, 1'b0, 1'b0, 1'b1);
      end
      rd(OFS_STS, r); check("R6", "edge mode leaves status clear", 64'(r), 64'd0);

      // R6 level mode and write-one-to-clear
      run("R6", 32'd500, 5, 1, 32'h0, 32'h6, 20, 1'b1, 1'b0, 1'b1);
      rd(OFS_STS, r); check("R6", "status set in level mode", 64'(r), 64'd1);
      wr(OFS_STS, 32'h0);
      check("R6", "writing zero keeps irq", 64'(irq), 64'd1);
      wr(OFS_STS, 32'h1);
      check("R6", "writing one drops irq", 64'(irq), 64'd0);
      rd(OFS_STS, r); check("R6", "status cleared", 64'(r), 64'd0);

      // R7 interrupt enable off, then counter stopped on a match
      run("R7", 32'd900, 3, 1, 32'h0, 32'h2, 20, 1'b1, 1'b0, 1'b0);
      rd(OFS_STS, r); check("R7", "no status with enable off", 64'(r), 64'd0);
      wr(OFS_GCFG, 32'h0);
      wr(OFS_CFG, 32'h6);
      wr(OFS_CNT_LO, 32'd77);
      wr(OFS_CNT_HI, 32'h0);
      wr(OFS_CMP_LO, 32'd77);
      wr(OFS_CMP_HI, 32'h0);
      repeat (10) @(negedge clk);
      check("R7", "no irq while stopped", 64'(irq), 64'd0);
      rd(OFS_STS, r); check("R7", "no status while stopped", 64'(r), 64'd0);

      // R8 periodic edge: period 9, first match 4 cycles out
      run("R8", 32'd100, 4, 9, 32'h0, 32'h4C, 40, 1'b0, 1'b1, 1'b1);
      run("R8", 32'd3000, 0, 5, 32'h0, 32'h4C, 30, 1'b0, 1'b1, 1'b1);

      // R9 32-bit compare ignores the unreachable high half
      run("R9", 32'd1000, 10, 1, 32'h7, 32'h104, 20, 1'b0, 1'b0, 1'b1);
      run("R9", 32'd1000, 10, 1, 32'h7, 32'h004, 20, 1'b0, 1'b0, 1'b0);

      wr(OFS_GCFG, 32'h0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule